// File: doc/BRIEF.md
# Infrared pulse run-length encoder

This block turns the demodulated output of an infrared receiver into a stream of run-length bytes. The raw line is synchronised, optionally inverted, then sampled once per prescaler period. Every stretch of constant level becomes one byte that carries the level and the stretch length in samples. Short glitches are folded into the run around them. A long quiet stretch closes the packet. The packet is closed by a final byte for the quiet run, together with a one-cycle packet-end pulse.

Downstream logic, such as a FIFO and an interrupt source, consumes the `valid_o` strobes and `pkt_end_o`. Configuration comes in on plain inputs: two enables, a two-bit mode field, the invert bit and the noise and idle thresholds. These inputs should only change while reception is off or the line is idle.

Top module: `ir_run_encoder`

## Requirements
- R1: Reception is active only when `glb_en_i` and `rx_en_i` are both 1 and `mode_i` equals 2'b11. While it is inactive, no byte and no packet-end pulse is produced.
- R2: One sample is taken every `PRESCALE` clock cycles (default 64). A level held for k*`PRESCALE` consecutive cycles during active reception yields exactly k samples.
- R3: Each output byte has the run level in bit 7 (1 = mark, meaning a sampled level of 1) and the run length in samples minus one in bits 6:0. The byte is emitted when the run ends.
- R4: With `invert_i` = 1 the line is inverted before sampling, so a low `ir_i` is treated as a mark.
- R5: A stretch of at most `noise_thr_i` samples at the opposite level is merged into the current run. A level change is accepted on the (`noise_thr_i`+1)-th consecutive differing sample, and those samples count toward the new run.
- R6: When a run grows past 128 samples, a byte with bits 6:0 = 7'h7F is emitted and 128 samples are removed from the count. A run of exactly 128 samples gives a single 7'h7F byte.
- R7: When a space run exceeds `idle_thr_i` samples, the block emits that run's byte together with a one-cycle `pkt_end_o` pulse. After that it emits nothing more until a mark is accepted, and a packet-end byte always has bit 7 = 0.
- R8: Leaving the active state discards the partial run and restarts the prescaler. The block then resumes in the idle state, where space samples produce nothing.
- R9: After reset `valid_o`, `pkt_end_o` and `data_o` are 0, and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ir_i | input | 1 | Raw demodulated receiver line |
| glb_en_i | input | 1 | Global enable |
| rx_en_i | input | 1 | Receive enable |
| mode_i | input | 2 | Mode field, 2'b11 selects reception |
| invert_i | input | 1 | Invert line before sampling |
| noise_thr_i | input | 6 | Glitch threshold in samples |
| idle_thr_i | input | 8 | Idle threshold in samples |
| data_o | output | 8 | Run byte: level in bit 7, length-1 in bits 6:0 |
| valid_o | output | 1 | One-cycle strobe for data_o |
| pkt_end_o | output | 1 | One-cycle packet-end pulse |

## Verification
The hardest situations to reach are runs that cross the 128-sample chunk boundary and glitches that sit inside both mark and space runs. They only appear after hundreds of samples or at exact sample counts. The bench overrides `PRESCALE` to a small value and drives the line in whole multiples of the sample period. Because any window of that length contains exactly k samples whatever the prescaler phase, exact counts such as 128, 300 and a one-sample glitch against a threshold of one can be placed directly. The scoreboard queues the hand-derived bytes and packet-end markers, and any extra output counts as a failure.

// File: rtl/ir_enc_pkg.sv
package ir_enc_pkg;
  localparam int unsigned NTHR_W   = 6;
  localparam int unsigned ITHR_W   = 8;
  localparam int unsigned CODE_W   = 7;
  localparam int unsigned CHUNK    = 1 << CODE_W;
  localparam int unsigned RUN_W    = CODE_W + 2;
  localparam int unsigned IDLE_W   = ITHR_W + 1;
  localparam int unsigned ADD_W    = NTHR_W + 1;
  localparam logic [1:0]  MODE_RX  = 2'b11;

  typedef logic [CODE_W:0] run_byte_t;
endpackage

// File: rtl/ir_enc_sync.sv
module ir_enc_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[0], d_i};
  end

  assign q_o = sync_q[1];
endmodule

// File: rtl/ir_enc_prescale.sv
module ir_enc_prescale #(
  parameter int unsigned DIV = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!en_i)       cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);

  generate
    if (DIV > 1) begin : g_gap
      AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o); // R2
    end
  endgenerate
endmodule

// File: rtl/ir_enc_filter.sv
module ir_enc_filter
  import ir_enc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              sample_i,
  input  logic [NTHR_W-1:0] noise_thr_i,
  output logic              step_o,
  output logic              level_o,
  output logic              commit_o,
  output logic [ADD_W-1:0]  add_o
);
  logic              lvl_q;
  logic [NTHR_W-1:0] pend_q;
  logic              differ;

  assign differ   = sample_i != lvl_q;
  assign step_o   = en_i && tick_i;
  assign commit_o = step_o && differ && (pend_q >= noise_thr_i);
  // samples credited to the run: held glitch samples plus this one
  assign add_o    = (!differ || commit_o) ? ({1'b0, pend_q} + 1'b1) : '0;
  assign level_o  = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b0;
      pend_q <= '0;
    end else if (!en_i) begin
      lvl_q  <= 1'b0;
      pend_q <= '0;
    end else if (tick_i) begin
      if (!differ) pend_q <= '0;
      else if (commit_o) begin
        lvl_q  <= ~lvl_q;
        pend_q <= '0;
      end else pend_q <= pend_q + 1'b1;
    end
  end

  AST_COMMIT_FLIPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> (level_o != $past(level_o))); // R5
  AST_HOLD_NO_CREDIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && !commit_o && sample_i != level_o) |-> (add_o == '0)); // R5
endmodule

// File: rtl/ir_enc_runlen.sv
module ir_enc_runlen
  import ir_enc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              step_i,
  input  logic              level_i,
  input  logic              commit_i,
  input  logic [ADD_W-1:0]  add_i,
  input  logic [ITHR_W-1:0] idle_thr_i,
  output run_byte_t         data_o,
  output logic              valid_o,
  output logic              pkt_end_o
);
  localparam logic [RUN_W-1:0]  CHUNK_N  = RUN_W'(CHUNK);
  localparam logic [IDLE_W-1:0] IDLE_MAX = '1;

  logic [RUN_W-1:0]  run_q, run_d, run_nxt, run_m1;
  logic [IDLE_W-1:0] idle_q, idle_d, idle_sum;
  logic              quiet_q, quiet_d;
  logic              emit, flush;
  run_byte_t         byte_d;

  assign run_nxt  = run_q + RUN_W'(add_i);
  assign idle_sum = idle_q + IDLE_W'(add_i);
  assign run_m1   = run_q - 1'b1;

  always_comb begin
    run_d   = run_q;
    idle_d  = idle_q;
    quiet_d = quiet_q;
    emit    = 1'b0;
    flush   = 1'b0;
    byte_d  = '0;
    if (step_i) begin
      if (commit_i) begin
        emit    = !quiet_q;
        byte_d  = {level_i, run_m1[CODE_W-1:0]};
        run_d   = RUN_W'(add_i);
        idle_d  = IDLE_W'(add_i);
        quiet_d = 1'b0;
      end else if (!quiet_q) begin
        idle_d = (idle_sum < idle_q) ? IDLE_MAX : idle_sum;
        if (run_nxt > CHUNK_N) begin
          emit   = 1'b1;
          byte_d = {level_i, {CODE_W{1'b1}}};
          run_d  = run_nxt - CHUNK_N;
        end else if (!level_i && (idle_d > IDLE_W'(idle_thr_i))) begin
          emit    = 1'b1;
          flush   = 1'b1;
          byte_d  = {1'b0, run_nxt[CODE_W-1:0] - 1'b1};
          run_d   = '0;
          quiet_d = 1'b1;
        end else begin
          run_d = run_nxt;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= '0;
      idle_q    <= '0;
      quiet_q   <= 1'b1;
      valid_o   <= 1'b0;
      pkt_end_o <= 1'b0;
      data_o    <= '0;
    end else if (!en_i) begin
      run_q     <= '0;
      idle_q    <= '0;
      quiet_q   <= 1'b1;
      valid_o   <= 1'b0;
      pkt_end_o <= 1'b0;
    end else begin
      run_q     <= run_d;
      idle_q    <= idle_d;
      quiet_q   <= quiet_d;
      valid_o   <= emit;
      pkt_end_o <= flush;
      if (emit) data_o <= byte_d;
    end
  end

  AST_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= CHUNK_N); // R6
  AST_END_IS_SPACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_end_o |-> (valid_o && !data_o[CODE_W])); // R7
  AST_QUIET_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet_q && !commit_i) |=> !valid_o); // R7
  AST_END_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_end_o |=> !pkt_end_o); // R7
endmodule

// File: rtl/ir_run_encoder.sv
module ir_run_encoder
  import ir_enc_pkg::*;
#(
  parameter int unsigned PRESCALE = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ir_i,
  input  logic       glb_en_i,
  input  logic       rx_en_i,
  input  logic [1:0] mode_i,
  input  logic       invert_i,
  input  logic [5:0] noise_thr_i,
  input  logic [7:0] idle_thr_i,
  output logic [7:0] data_o,
  output logic       valid_o,
  output logic       pkt_end_o
);
  logic             active, ir_s, tick, step, level, commit;
  logic [ADD_W-1:0] add;

  assign active = glb_en_i && rx_en_i && (mode_i == MODE_RX);

  ir_enc_sync i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ir_i),
    .q_o   (ir_s)
  );

  ir_enc_prescale #(.DIV(PRESCALE)) i_prescale (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (active),
    .tick_o(tick)
  );

  ir_enc_filter i_filter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (active),
    .tick_i     (tick),
    .sample_i   (ir_s ^ invert_i),
    .noise_thr_i(noise_thr_i),
    .step_o     (step),
    .level_o    (level),
    .commit_o   (commit),
    .add_o      (add)
  );

  ir_enc_runlen i_runlen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (active),
    .step_i    (step),
    .level_i   (level),
    .commit_i  (commit),
    .add_i     (add),
    .idle_thr_i(idle_thr_i),
    .data_o    (data_o),
    .valid_o   (valid_o),
    .pkt_end_o (pkt_end_o)
  );

  AST_OUT_NEEDS_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o || pkt_end_o) |-> $past(active)); // R1
endmodule

// File: tb/test_ir_run_encoder.sv
module test_ir_run_encoder;
  localparam int P = 4;
  localparam logic [8:0] PE = 9'h100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ir = 1'b0, glb_en = 1'b0, rx_en = 1'b0, invert = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [5:0] nthr = 6'd1;
  logic [7:0] ithr = 8'd20;
  logic [7:0] data;
  logic       valid, pkt_end;

  int checks = 0, fails = 0;
  logic [8:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  ir_run_encoder #(.PRESCALE(P)) i_ir_run_encoder (
    .clk_i(clk), .rst_ni(rst_n), .ir_i(ir), .glb_en_i(glb_en), .rx_en_i(rx_en),
    .mode_i(mode), .invert_i(invert), .noise_thr_i(nthr), .idle_thr_i(ithr),
    .data_o(data), .valid_o(valid), .pkt_end_o(pkt_end)
  );

  task automatic expect_item(input logic [8:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic compare(input logic [8:0] got);
    checks++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL unexpected output: got %h expected nothing", got);
    end else begin
      logic [8:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (got !== e) begin
        fails++;
        $display("FAIL %s: got %h expected %h", t, got, e);
      end
    end
  endtask

  // monitor: byte first, then packet-end marker
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid)   compare({1'b0, data});
      if (pkt_end) compare(PE);
    end
  end

  // level is logical (after inversion); n samples
  task automatic drive(input logic lvl, input int n);
    ir = lvl ^ invert;
    repeat (n * P) @(negedge clk);
  endtask

  task automatic check_drained(input string tag);
    drive(1'b0, 5);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL %s: got %0d pending items expected 0", tag, exp_q.size());
      exp_q.delete();
      tag_q.delete();
    end
  endtask

  task automatic set_active(input logic on);
    @(negedge clk);
    glb_en = on; rx_en = on; mode = on ? 2'b11 : 2'b00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (valid !== 1'b0 || pkt_end !== 1'b0 || data !== 8'h00) begin
      fails++;
      $display("FAIL R9: got v=%b pe=%b d=%h expected 0 0 00", valid, pkt_end, data);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    set_active(1'b1);
    drive(1'b0, 10);
    // R3 R2 basic encoding
    expect_item(9'h084, "R3 mark5"); expect_item(9'h006, "R3 space7");
    expect_item(9'h082, "R2 mark3"); expect_item(9'h014, "R7 flush");
    expect_item(PE, "R7 end");
    drive(1'b1, 5); drive(1'b0, 7); drive(1'b1, 3); drive(1'b0, 30);
    check_drained("R7 drain1");

    // R5 glitch inside mark and inside space
    expect_item(9'h08A, "R5 mark glitch"); expect_item(9'h014, "R7 flush");
    expect_item(PE, "R7 end");
    drive(1'b1, 6); drive(1'b0, 1); drive(1'b1, 4); drive(1'b0, 25);
    check_drained("R5 drain");
    expect_item(9'h084, "R5 mark5"); expect_item(9'h010, "R5 space glitch");
    expect_item(9'h082, "R5 mark3"); expect_item(9'h014, "R7 flush");
    expect_item(PE, "R7 end");
    drive(1'b1, 5); drive(1'b0, 8); drive(1'b1, 1); drive(1'b0, 8);
    drive(1'b1, 3); drive(1'b0, 25);
    check_drained("R5 drain2");

    // R6 long runs
    expect_item(9'h0FF, "R6 chunk1"); expect_item(9'h0FF, "R6 chunk2");
    expect_item(9'h0AB, "R6 rest"); expect_item(9'h014, "R7 flush");
    expect_item(PE, "R7 end");
    drive(1'b1, 300); drive(1'b0, 25);
    check_drained("R6 drain");
    expect_item(9'h0FF, "R6 exact128"); expect_item(9'h014, "R7 flush");
    expect_item(PE, "R7 end");
    drive(1'b1, 128); drive(1'b0, 25);
    check_drained("R6 drain2");

    // R5 R7 other thresholds
    @(negedge clk); nthr = 6'd3; ithr = 8'd5;
    expect_item(9'h089, "R5 thr3 mark"); expect_item(9'h005, "R7 thr5 flush");
    expect_item(PE, "R7 end");
    drive(1'b1, 3); drive(1'b0, 5); drive(1'b1, 10); drive(1'b0, 10);
    check_drained("R7 drain");
    @(negedge clk); nthr = 6'd1; ithr = 8'd20;

    // R4 inversion
    set_active(1'b0);
    invert = 1'b1;
    set_active(1'b1);
    drive(1'b0, 5);
    expect_item(9'h083, "R4 inverted mark"); expect_item(9'h014, "R7 flush");
    expect_item(PE, "R7 end");
    drive(1'b1, 4); drive(1'b0, 25);
    check_drained("R4 drain");
    set_active(1'b0);
    invert = 1'b0;
    set_active(1'b1);

    // R1 mode field not 2'b11: nothing
    @(negedge clk); mode = 2'b01;
    drive(1'b1, 5); drive(1'b0, 25);
    check_drained("R1 mode01");
    @(negedge clk); mode = 2'b11; glb_en = 1'b0;
    drive(1'b1, 5); drive(1'b0, 25);
    check_drained("R1 glb off");
    @(negedge clk); glb_en = 1'b1;

    // R8 disable mid-run discards
    drive(1'b0, 5); drive(1'b1, 20);
    @(negedge clk); rx_en = 1'b0;
    drive(1'b1, 5); drive(1'b0, 5);
    @(negedge clk); rx_en = 1'b1;
    drive(1'b0, 10);
    expect_item(9'h082, "R8 after reenable"); expect_item(9'h014, "R7 flush");
    expect_item(PE, "R7 end");
    drive(1'b1, 3); drive(1'b0, 25);
    check_drained("R8 drain");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule